// File: doc/BRIEF.md
# SPI-Mode Card Byte Transport

This block carries 8-bit tokens between a host and up to two memory cards that run in their serial-peripheral operating mode. In that mode the card's command wire becomes an output-only line from this block, carrying command tokens and write data. The card's data wire becomes an input-only line, carrying response tokens and read data. A separate active-low chip select for each card picks which card takes part in an exchange. Command contents, CRC handling and the act of switching a card into this mode all belong to other logic.

The host hands over one byte at a time on a valid/ready port. With the first byte it gives the card number, a transfer-kind code and a "last" flag. The block asserts that card's chip select and puts the first bit on the command line in the very next cycle. It then runs eight serial clock pulses, shifting most-significant bit first. The outgoing bit changes on the falling serial edge and the incoming bit is sampled on the rising edge. The received byte goes back to the host with a one-cycle valid pulse. When the "last" flag is clear, the chip select stays low and further bytes go to the same card until a byte marked last completes.

The serial mode can only be left by removing card power, so the mode flag is sticky until reset. Only single-block transfers are legal in this mode, so multi-block and stream requests are turned away without touching the card.

Top module: `card_spi_xport`

## Requirements
- R1: After reset both chip selects are high, the serial clock is low, resp_valid and reject are low, mode_on is low and req_ready is high.
- R2: A one-cycle pulse on mode_req sets mode_on in the following cycle, and mode_on then stays high until reset.
- R3: A request taken while mode_on is low is refused. reject pulses high for exactly one cycle, one cycle after the accepting edge, and no chip select goes low.
- R4: Kind codes 2'b00 (command exchange) and 2'b01 (single block) are accepted. Codes 2'b10 (multi-block) and 2'b11 (stream) are refused in the same way as in R3.
- R5: In the cycle after an accepted opening byte, cs_n[req_card] is low and the other chip select is high. At no time are both chip selects low.
- R6: Bytes leave on cmd_out most-significant bit first. The first bit is present in the cycle after acceptance. cmd_out never changes in a cycle where the serial clock rises.
- R7: dat_in is sampled at each rising serial edge, most-significant bit first, and the eight samples form resp_tok.
- R8: The serial clock stays low while no byte is being shifted. During a byte it spends HALF_DIV cycles low and HALF_DIV cycles high per bit, which gives eight rising edges per byte.
- R9: resp_valid is a single-cycle pulse that rises exactly 16*HALF_DIV cycles after the accepting edge, together with the final falling serial edge.
- R10: When a byte with req_last low completes, its chip select stays low. The next byte goes to that same card, and req_card and req_kind are ignored for it.
- R11: When a byte with req_last high completes, all chip selects are high in the same cycle in which resp_valid is high.
- R12: req_ready is low while a byte is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 1 | Pulse that enters the serial card mode |
| mode_on | output | 1 | Sticky flag: serial card mode is active |
| req_valid | input | 1 | Host offers a byte |
| req_ready | output | 1 | Block can take a byte |
| req_card | input | CARD_W | Card to address on an opening byte |
| req_kind | input | 2 | Transfer kind code on an opening byte |
| req_last | input | 1 | Release the chip select after this byte |
| req_tok | input | TOK_W | Byte to send to the card |
| resp_valid | output | 1 | One-cycle pulse: resp_tok holds the received byte |
| resp_tok | output | TOK_W | Byte received from the card |
| reject | output | 1 | One-cycle pulse: request refused |
| sclk | output | 1 | Serial clock to the card |
| cmd_out | output | 1 | Command and write-data line to the card |
| dat_in | input | 1 | Response and read-data line from the card |
| cs_n | output | NUM_CARDS | Active-low chip selects, one per card |

## Verification
A refusal shows up on reject one cycle after the accepting edge, and a sticky mode change shows up on mode_on one cycle after the pulse. The chip select and the first outgoing bit appear one cycle after acceptance. The returned byte is due exactly 16*HALF_DIV cycles after acceptance. The driver records the time of each accepting edge and pushes it into the scoreboard together with the expected byte and release flag. The monitor samples on the falling system clock edge and checks the measured distance, the byte and the chip-select state on the resp_valid cycle. A bench card model checks serial-clock spacing and the byte shifted in on each rising edge.

// File: rtl/card_spi_pkg.sv
package card_spi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } xport_state_e;

  localparam logic [1:0] KIND_CMD    = 2'b00;
  localparam logic [1:0] KIND_SINGLE = 2'b01;
  localparam logic [1:0] KIND_MULTI  = 2'b10;
  localparam logic [1:0] KIND_STREAM = 2'b11;

  // Only command exchanges and single-block transfers are legal in serial mode.
  function automatic logic kind_allowed(input logic [1:0] kind);
    return (kind == KIND_CMD) || (kind == KIND_SINGLE);
  endfunction

endpackage

// File: rtl/card_spi_rst_sync.sv
module card_spi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/card_spi_tick.sv
module card_spi_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    tick   = run && (cnt_q == CNT_TOP);
    cnt_en = 1'b1;
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/card_spi_shift.sv
module card_spi_shift #(
  parameter int TOK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TOK_W-1:0] load_tok,
  input  logic             capture,
  input  logic             advance,
  input  logic             sdi,
  output logic             sdo,
  output logic [TOK_W-1:0] rx_tok
);

  logic [TOK_W-1:0] tx_q, tx_d;
  logic [TOK_W-1:0] rx_q, rx_d;
  logic             tx_en, rx_en;

  always_comb begin
    tx_en = load || advance;
    rx_en = capture;
    if (load) begin
      tx_d = load_tok;
    end else begin
      tx_d = {tx_q[TOK_W-2:0], 1'b0};
    end
    rx_d = {rx_q[TOK_W-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (tx_en) begin
      tx_q <= tx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (rx_en) begin
      rx_q <= rx_d;
    end
  end

  assign sdo    = tx_q[TOK_W-1];
  assign rx_tok = rx_q;

endmodule

// File: rtl/card_spi_fsm.sv
module card_spi_fsm
  import card_spi_pkg::*;
#(
  parameter int TOK_W     = 8,
  parameter int NUM_CARDS = 2,
  parameter int CARD_W    = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_on,
  input  logic                 req_valid,
  input  logic [CARD_W-1:0]    req_card,
  input  logic [1:0]           req_kind,
  input  logic                 req_last,
  input  logic                 tick,
  output logic                 req_ready,
  output logic                 load,
  output logic                 capture,
  output logic                 advance,
  output logic                 run,
  output logic                 sclk,
  output logic [NUM_CARDS-1:0] cs_n,
  output logic                 resp_valid,
  output logic                 reject
);

  localparam int BW = (TOK_W > 1) ? $clog2(TOK_W) : 1;
  localparam logic [BW-1:0] BIT_LAST = BW'(TOK_W - 1);

  xport_state_e      state_q, state_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [CARD_W-1:0] sel_q, sel_d;
  logic              last_q, last_d;
  logic              sclk_q, sclk_d;
  logic              csa_q, csa_d;
  logic              resp_q, resp_d;
  logic              rej_q, rej_d;

  logic accept, open_ok, open_bad, cont, rise, fall, final_fall;

  always_comb begin
    req_ready  = (state_q != ST_SHIFT);
    accept     = req_valid && req_ready;
    open_ok    = accept && (state_q == ST_IDLE) && mode_on && kind_allowed(req_kind);
    open_bad   = accept && (state_q == ST_IDLE) && !(mode_on && kind_allowed(req_kind));
    cont       = accept && (state_q == ST_HOLD);
    load       = open_ok || cont;
    run        = (state_q == ST_SHIFT);
    rise       = run && tick && !sclk_q;
    fall       = run && tick && sclk_q;
    final_fall = fall && (bit_q == BIT_LAST);
    capture    = rise;
    advance    = fall && !final_fall;
  end

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sel_d   = sel_q;
    last_d  = last_q;
    sclk_d  = sclk_q;
    csa_d   = csa_q;
    resp_d  = final_fall;
    rej_d   = open_bad;

    unique case (state_q)
      ST_IDLE: begin
        if (open_ok) begin
          state_d = ST_SHIFT;
          sel_d   = req_card;
          csa_d   = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (final_fall) begin
          state_d = last_q ? ST_IDLE : ST_HOLD;
          if (last_q) begin
            csa_d = 1'b0;
          end
        end
      end
      ST_HOLD: begin
        if (cont) begin
          state_d = ST_SHIFT;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (load) begin
      bit_d  = '0;
      last_d = req_last;
    end else if (advance) begin
      bit_d = bit_q + 1'b1;
    end

    if (rise) begin
      sclk_d = 1'b1;
    end else if (fall) begin
      sclk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sel_q   <= '0;
      last_q  <= 1'b0;
      sclk_q  <= 1'b0;
      csa_q   <= 1'b0;
      resp_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sel_q   <= sel_d;
      last_q  <= last_d;
      sclk_q  <= sclk_d;
      csa_q   <= csa_d;
      resp_q  <= resp_d;
      rej_q   <= rej_d;
    end
  end

  for (genvar g = 0; g < NUM_CARDS; g++) begin : g_cs
    assign cs_n[g] = !(csa_q && (sel_q == CARD_W'(g)));
  end

  assign sclk       = sclk_q;
  assign resp_valid = resp_q;
  assign reject     = rej_q;

endmodule

// File: rtl/card_spi_xport.sv
module card_spi_xport
  import card_spi_pkg::*;
#(
  parameter int HALF_DIV  = 4,
  parameter int TOK_W     = 8,
  parameter int NUM_CARDS = 2,
  parameter int CARD_W    = (NUM_CARDS > 1) ? $clog2(NUM_CARDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_req,
  output logic                 mode_on,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [CARD_W-1:0]    req_card,
  input  logic [1:0]           req_kind,
  input  logic                 req_last,
  input  logic [TOK_W-1:0]     req_tok,
  output logic                 resp_valid,
  output logic [TOK_W-1:0]     resp_tok,
  output logic                 reject,
  output logic                 sclk,
  output logic                 cmd_out,
  input  logic                 dat_in,
  output logic [NUM_CARDS-1:0] cs_n
);

  logic rst_n_i;
  logic mode_q, mode_d, mode_en;
  logic tick, run, load, capture, advance;

  card_spi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  // Sticky mode flag: leaving the serial mode needs a power cycle of the card.
  always_comb begin
    mode_en = mode_req && !mode_q;
    mode_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mode_q <= 1'b0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign mode_on = mode_q;

  card_spi_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n_i),
    .run   (run),
    .tick  (tick)
  );

  card_spi_fsm #(
    .TOK_W     (TOK_W),
    .NUM_CARDS (NUM_CARDS),
    .CARD_W    (CARD_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .mode_on    (mode_q),
    .req_valid  (req_valid),
    .req_card   (req_card),
    .req_kind   (req_kind),
    .req_last   (req_last),
    .tick       (tick),
    .req_ready  (req_ready),
    .load       (load),
    .capture    (capture),
    .advance    (advance),
    .run        (run),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .resp_valid (resp_valid),
    .reject     (reject)
  );

  card_spi_shift #(.TOK_W(TOK_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (load),
    .load_tok (req_tok),
    .capture  (capture),
    .advance  (advance),
    .sdi      (dat_in),
    .sdo      (cmd_out),
    .rx_tok   (resp_tok)
  );

endmodule

// File: rtl/card_spi_xport_chk.sv
module card_spi_xport_chk #(
  parameter int NUM_CARDS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mode_on,
  input logic                 req_ready,
  input logic                 resp_valid,
  input logic                 reject,
  input logic                 sclk,
  input logic                 cmd_out,
  input logic [NUM_CARDS-1:0] cs_n
);

  p_sticky_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_on |=> mode_on);

  p_reject_no_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (&cs_n));

  p_single_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  p_out_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(cmd_out));

  p_idle_sclk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sclk);

  p_done_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $fell(sclk));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !req_ready);

endmodule

bind card_spi_xport card_spi_xport_chk #(.NUM_CARDS(NUM_CARDS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_on    (mode_on),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .reject     (reject),
  .sclk       (sclk),
  .cmd_out    (cmd_out),
  .cs_n       (cs_n)
);

// File: tb/sim_card_spi_xport.sv
`timescale 1ns/1ps
module sim_card_spi_xport;

  localparam int HALF_DIV = 2;
  localparam int CLK_T    = 8;
  localparam int HALF_T   = CLK_T / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_req = 1'b0;
  logic       mode_on;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [0:0] req_card = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic       req_last = 1'b0;
  logic [7:0] req_tok = 8'h00;
  logic       resp_valid;
  logic [7:0] resp_tok;
  logic       reject;
  logic       sclk;
  logic       cmd_out;
  logic       dat_in;
  logic [1:0] cs_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  card_spi_xport #(.HALF_DIV(HALF_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_on(mode_on),
    .req_valid(req_valid), .req_ready(req_ready), .req_card(req_card),
    .req_kind(req_kind), .req_last(req_last), .req_tok(req_tok),
    .resp_valid(resp_valid), .resp_tok(resp_tok), .reject(reject),
    .sclk(sclk), .cmd_out(cmd_out), .dat_in(dat_in), .cs_n(cs_n)
  );

  always #(HALF_T) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard queues
  logic [7:0] exp_host[$];
  bit         exp_last[$];
  logic       exp_cardno[$];
  time        exp_acc[$];
  logic [8:0] exp_card[$];

  // Card model: shifts cmd_out in on rising sclk, presents its byte MSB first.
  logic [7:0] card_cur = 8'h00;
  logic [7:0] card_rx  = 8'h00;
  logic [2:0] cbit     = 3'd0;
  time        last_rise = 0;

  assign dat_in = card_cur[3'd7 - cbit];

  always @(posedge sclk) begin
    logic [8:0] e;
    logic       who;
    if (cbit != 3'd0)
      check(($time - last_rise) == 2 * HALF_DIV * CLK_T, "R8 sclk spacing",
            int'($time - last_rise), 2 * HALF_DIV * CLK_T);
    last_rise = $time;
    card_rx = {card_rx[6:0], cmd_out};
    if (cbit == 3'd7) begin
      cbit = 3'd0;
      who = (cs_n == 2'b10) ? 1'b0 : 1'b1;
      check(cs_n == 2'b10 || cs_n == 2'b01, "R5 one cs during byte", cs_n, 2'b10);
      if (exp_card.size() == 0) begin
        check(1'b0, "R6 unexpected card byte", card_rx, 0);
      end else begin
        e = exp_card.pop_front();
        check({who, card_rx} == e, "R6/R10 card received byte",
              {who, card_rx}, e);
      end
    end else begin
      cbit = cbit + 3'd1;
    end
  end

  // Monitor: results compared as the design produces them.
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_host.size() == 0) begin
        check(1'b0, "R9 unexpected resp_valid", resp_tok, 0);
      end else begin
        logic [7:0] eb;
        bit         el;
        logic       ec;
        time        ta;
        eb = exp_host.pop_front();
        el = exp_last.pop_front();
        ec = exp_cardno.pop_front();
        ta = exp_acc.pop_front();
        check(resp_tok == eb, "R7 resp_tok", resp_tok, eb);
        check(($time - ta) == 16 * HALF_DIV * CLK_T + HALF_T, "R9 latency",
              int'($time - ta), 16 * HALF_DIV * CLK_T + HALF_T);
        if (el)
          check(cs_n == 2'b11, "R11 release on last", cs_n, 2'b11);
        else
          check(cs_n[ec] == 1'b0, "R10 cs held", cs_n, ec ? 2'b01 : 2'b10);
      end
    end
  end

  bit   holding = 1'b0;
  logic held_card = 1'b0;

  task automatic xfer(input logic card, input logic [1:0] kind, input bit last,
                      input logic [7:0] tx, input logic [7:0] rsp);
    logic tgt;
    tgt = holding ? held_card : card;
    @(negedge clk);
    card_cur = rsp;
    exp_card.push_back({tgt, tx});
    exp_host.push_back(rsp);
    exp_last.push_back(last);
    exp_cardno.push_back(tgt);
    req_card = card; req_kind = kind; req_last = last; req_tok = tx;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_acc.push_back($time + HALF_T);
    @(negedge clk);
    req_valid = 1'b0;
    check(cs_n[tgt] == 1'b0 && cs_n[!tgt] == 1'b1, "R5 cs after accept",
          cs_n, tgt ? 2'b01 : 2'b10);
    check(cmd_out == tx[7], "R6 MSB first", cmd_out, tx[7]);
    @(negedge clk);
    check(req_ready == 1'b0, "R12 busy", req_ready, 0);
    while (exp_host.size() != 0) @(posedge clk);
    @(negedge clk);
    holding = !last;
    held_card = tgt;
  endtask

  task automatic try_reject(input logic card, input logic [1:0] kind, input string req);
    @(negedge clk);
    req_card = card; req_kind = kind; req_last = 1'b1; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(reject == 1'b1, req, reject, 1);
    check(cs_n == 2'b11, req, cs_n, 2'b11);
    @(negedge clk);
    check(reject == 1'b0, req, reject, 0);
    check(cs_n == 2'b11 && sclk == 1'b0, req, {sclk, cs_n}, 3'b011);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(cs_n == 2'b11 && sclk == 1'b0, "R1 reset lines", {sclk, cs_n}, 3'b011);
    check(!resp_valid && !reject && !mode_on && req_ready, "R1 reset flags",
          {resp_valid, reject, mode_on, req_ready}, 4'b0001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    try_reject(1'b0, 2'b00, "R3 refused without mode");

    mode_req = 1'b1;
    @(negedge clk);
    mode_req = 1'b0;
    check(mode_on == 1'b1, "R2 mode set", mode_on, 1);

    try_reject(1'b0, 2'b10, "R4 multi-block refused");
    try_reject(1'b1, 2'b11, "R4 stream refused");

    xfer(1'b0, 2'b00, 1'b1, 8'hA5, 8'h3C);   // R4 command kind accepted
    xfer(1'b1, 2'b01, 1'b1, 8'h81, 8'h7E);   // R4 single-block kind accepted
    xfer(1'b0, 2'b00, 1'b1, 8'h00, 8'hFF);
    xfer(1'b0, 2'b00, 1'b1, 8'hFF, 8'h00);

    // R10: held exchange on card 1; the second byte carries card 0 and a
    // refused kind, both ignored while the chip select is held.
    xfer(1'b1, 2'b01, 1'b0, 8'h5A, 8'hC3);
    repeat (6) @(negedge clk);
    check(cs_n == 2'b01 && sclk == 1'b0, "R10/R8 hold idle", {sclk, cs_n}, 3'b001);
    xfer(1'b0, 2'b11, 1'b0, 8'h12, 8'h34);
    xfer(1'b0, 2'b10, 1'b1, 8'hE7, 8'h96);
    check(cs_n == 2'b11, "R11 released", cs_n, 2'b11);

    mode_req = 1'b1;
    @(negedge clk);
    mode_req = 1'b0;
    repeat (3) @(negedge clk);
    check(mode_on == 1'b1, "R2 mode sticky", mode_on, 1);
    check(exp_card.size() == 0, "R6 card bytes all seen", exp_card.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * CLK_T);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule